// File: doc/BRIEF.md
# Byte-wide memory-mapped GPIO port with peripheral window decode

This block sits on a 16-bit address and data bus and does two jobs. It splits the address space into a 512-byte peripheral window at the bottom of the map and ordinary memory above it. Every access in the window raises exactly one of 512 device selects. Every access above the window raises the memory chip select instead.

Inside the window, three byte registers form an eight-pin general-purpose port. A read-only input register shows the pin levels after a two-flop synchronizer. A read/write output register holds the levels that are driven. A read/write direction register gives each pin its own output enable. Because the output register reads back exactly what was last written, software can set, clear, toggle or add bits with read-modify-write sequences.

The bus is a plain single-cycle register interface, so it has no back-pressure. Writes take effect at the clock edge. Read data is combinational from the current address. A byte access moves data on bits 7:0. A word access uses the even-aligned pair of bytes, little-endian.

Top module: `gpio_port`

## Requirements
- R1: `mem_cs` is 1 exactly when any of `bus_addr[15:9]` is 1, and 0 when those bits are all zero (window 0x0000 to 0x01FF).
- R2: Inside the window, exactly one bit of `periph_sel` is 1, at the index given by the low nine bits of the access address (bit 0 forced to 0 for word accesses). Outside the window, `periph_sel` is all zero.
- R3: After reset, the direction register is 0x00, so every pin is an input (`pin_oe` = 0x00).
- R4: After reset, the output register is 0x00. A byte read at 0x0021 always returns, on `bus_rdata[7:0]`, the value last written there.
- R5: `pin_out` equals the output register and `pin_oe` equals the direction register. Each pin is an output exactly when its own direction bit is 1.
- R6: A byte read at 0x0020 returns `pin_in` as sampled through two clock edges. A level present before edge k is visible from edge k+1 on, and not before.
- R7: A write to 0x0020 changes no state. `pin_out` and `pin_oe` are unchanged, and the read keeps following the pins.
- R8: Reads of window addresses other than 0x0020 to 0x0022, and all reads with `mem_cs` = 1, return 0x0000. Writes outside the window change no register.
- R9: A byte access (`bus_byte` = 1) writes from `bus_wdata[7:0]` and returns data on `bus_rdata[7:0]` with bits 15:8 zero.
- R10: A word access (`bus_byte` = 0) aligns the address down to even. The even byte uses data bits 7:0 and the odd byte uses bits 15:8, for both write and read.
- R11: The direction register is at 0x0022 and is written and read back like the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_byte | input | 1 | 1 for byte access, 0 for word access |
| bus_rdata | output | 16 | Combinational read data |
| mem_cs | output | 1 | Memory chip select (address above the window) |
| periph_sel | output | 512 | One-hot device select inside the window |
| pin_in | input | 8 | Pin levels, asynchronous |
| pin_out | output | 8 | Pin drive levels |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
The bench builds the block with its default parameters. These are a 16-bit address, a nine-bit window, the port at 0x0020 to 0x0022 and a two-stage synchronizer. With these values the window edges 0x01FF/0x0200 and the register addresses with their upper-bit aliases (for example 0x0221) can all be reached with ordinary stimulus. Random addresses are biased toward the register bytes, the unmapped neighbour 0x0023 and the aliases, and mix byte and word accesses, so both lanes of each register are exercised. The pins change randomly every cycle, which brings the two-edge synchronizer latency into every input read.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Number of byte registers in the port
  localparam int GPIO_NREG = 3;

  // Register slot roles, used to pick the register variant
  typedef enum logic [1:0] {
    SLOT_PINS = 2'd0,
    SLOT_DRIVE = 2'd1,
    SLOT_DIR = 2'd2
  } gpio_slot_e;

  // Address used for the decode: word accesses align down to even
  function automatic logic [15:0] align_addr(input logic [15:0] a, input logic byte_acc);
    return {a[15:1], a[0] & byte_acc};
  endfunction
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec #(
  parameter int ADDR_W = 16,
  parameter int WIN_W = 9,
  localparam int SEL_N = 1 << WIN_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              mem_cs,
  output logic [SEL_N-1:0]  sel
);
  logic win_hit;

  assign mem_cs  = |addr[ADDR_W-1:WIN_W];
  assign win_hit = ~mem_cs;

  for (genvar i = 0; i < SEL_N; i++) begin : g_sel
    assign sel[i] = win_hit && (addr[WIN_W-1:0] == WIN_W'(i));
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_byte_reg.sv
module gpio_byte_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else if (wr_en) q <= wr_data;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int ADDR_W = 16,
  parameter int PORT_W = 8,
  parameter int WIN_W = 9,
  parameter int PINS_OFS = 'h20,
  parameter int DRIVE_OFS = 'h21,
  parameter int DIR_OFS = 'h22,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W = 2 * PORT_W,
  localparam int SEL_N = 1 << WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_byte,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mem_cs,
  output logic [SEL_N-1:0]  periph_sel,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);
  import gpio_pkg::*;

  localparam int NREG = GPIO_NREG;
  localparam int OFS [NREG] = '{PINS_OFS, DRIVE_OFS, DIR_OFS};

  logic [ADDR_W-1:0] dec_addr;
  logic [NREG-1:0]   hit_lo, hit_hi, wr_en;
  logic [PORT_W-1:0] reg_val [NREG];
  logic [PORT_W-1:0] wr_byte [NREG];
  logic [PORT_W-1:0] rd_lo, rd_hi;

  assign dec_addr = {bus_addr[ADDR_W-1:1], bus_addr[0] & bus_byte};

  gpio_addr_dec #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_dec (
    .addr   (dec_addr),
    .mem_cs (mem_cs),
    .sel    (periph_sel)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    // Even byte of the access: direct select
    assign hit_lo[g] = periph_sel[OFS[g]];
    // Odd byte of a word access: select of the even neighbour
    if (OFS[g] % 2 == 1) begin : g_odd
      assign hit_hi[g] = ~bus_byte & periph_sel[OFS[g]-1];
    end else begin : g_even
      assign hit_hi[g] = 1'b0;
    end
    assign wr_byte[g] = hit_lo[g] ? bus_wdata[PORT_W-1:0] : bus_wdata[DATA_W-1:PORT_W];

    if (gpio_slot_e'(g) == SLOT_PINS) begin : g_pins
      assign wr_en[g] = 1'b0;
      gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (reg_val[g])
      );
    end else begin : g_rw
      assign wr_en[g] = bus_we & (hit_lo[g] | hit_hi[g]);
      gpio_byte_reg #(.W(PORT_W), .RST_VAL('0)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en[g]),
        .wr_data (wr_byte[g]),
        .q       (reg_val[g])
      );
    end
  end

  always_comb begin
    rd_lo = '0;
    rd_hi = '0;
    for (int g = 0; g < NREG; g++) begin
      if (hit_lo[g]) rd_lo |= reg_val[g];
      if (hit_hi[g]) rd_hi |= reg_val[g];
    end
  end

  assign bus_rdata = {rd_hi, rd_lo};
  assign pin_out   = reg_val[SLOT_DRIVE];
  assign pin_oe    = reg_val[SLOT_DIR];
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int ADDR_W = 16,
  parameter int PORT_W = 8,
  parameter int WIN_W = 9,
  parameter int PINS_OFS = 'h20,
  parameter int DRIVE_OFS = 'h21,
  localparam int DATA_W = 2 * PORT_W,
  localparam int SEL_N = 1 << WIN_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_byte,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              mem_cs,
  input logic [SEL_N-1:0]  periph_sel,
  input logic [PORT_W-1:0] pin_out,
  input logic [PORT_W-1:0] pin_oe
);
  // R1 / R2: memory select and device selects are mutually exclusive
  a_r1_mem_excl: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs |-> (periph_sel == '0));
  a_r2_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs |-> ($countones(periph_sel) == 1));
  // R8: no write inside the window, no change on the pins
  a_r8_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we || mem_cs) |=> ($stable(pin_out) && $stable(pin_oe)));
  // R7: a byte write to the input register changes nothing
  a_r7_pins_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_byte && bus_addr == ADDR_W'(PINS_OFS)) |=> ($stable(pin_out) && $stable(pin_oe)));
  // R4: a byte read of the output register returns the driven value
  a_r4_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_byte && bus_addr == ADDR_W'(DRIVE_OFS)) |-> (bus_rdata == {{PORT_W{1'b0}}, pin_out}));
  // R9: a byte read never drives the upper lane
  a_r9_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_byte |-> (bus_rdata[DATA_W-1:PORT_W] == '0));
endmodule

bind gpio_port gpio_port_chk #(
  .ADDR_W(ADDR_W), .PORT_W(PORT_W), .WIN_W(WIN_W),
  .PINS_OFS(PINS_OFS), .DRIVE_OFS(DRIVE_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_byte(bus_byte), .bus_rdata(bus_rdata), .mem_cs(mem_cs),
  .periph_sel(periph_sel), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  bus_addr = '0;
  logic [15:0]  bus_wdata = '0;
  logic         bus_we = 1'b0;
  logic         bus_byte = 1'b1;
  logic [15:0]  bus_rdata;
  logic         mem_cs;
  logic [511:0] periph_sel;
  logic [7:0]   pin_in = '0;
  logic [7:0]   pin_out;
  logic [7:0]   pin_oe;

  int checks = 0;
  int errors = 0;

  // Model state computed from the requirements
  logic [7:0] m_out = '0, m_dir = '0, m_s1 = '0, m_s2 = '0;

  always #2 clk = ~clk;

  gpio_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_byte(bus_byte), .bus_rdata(bus_rdata),
    .mem_cs(mem_cs), .periph_sel(periph_sel), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input logic [15:0] a);
    if (a[15:9] != 0) return 8'h00;
    case (a)
      16'h0020: return m_s2;
      16'h0021: return m_out;
      16'h0022: return m_dir;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] exp_read(input logic [15:0] a, input logic b);
    logic [15:0] base;
    base = {a[15:1], 1'b0};
    if (b) return {8'h00, byte_at(a)};
    return {byte_at(base | 16'h1), byte_at(base)};
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    if (a == 16'h0021) m_out = d;
    else if (a == 16'h0022) m_dir = d;
  endtask

  task automatic cyc(input string tag, input logic [15:0] a, input logic [15:0] wd,
                     input logic we, input logic b, input logic [7:0] pins);
    logic [15:0] al;
    bus_addr = a; bus_wdata = wd; bus_we = we; bus_byte = b; pin_in = pins;
    #1;
    al = {a[15:1], a[0] & b};
    chk(tag, bus_rdata, exp_read(a, b));
    chk("R1 mem_cs", mem_cs, |a[15:9]);
    chk("R2 periph_sel", periph_sel == ((a[15:9] != 0) ? 512'd0 : (512'd1 << al[8:0])), 1);
    chk("R5 pin_out", pin_out, m_out);
    chk("R5 pin_oe", pin_oe, m_dir);
    @(posedge clk);
    if (we) begin
      if (b) model_write(a, wd[7:0]);
      else begin
        model_write({a[15:1], 1'b0}, wd[7:0]);
        model_write({a[15:1], 1'b1}, wd[15:8]);
      end
    end
    m_s2 = m_s1;
    m_s1 = pins;
    @(negedge clk);
  endtask

  function automatic logic [15:0] pick_addr();
    case ($urandom_range(0, 9))
      0, 1, 2: return 16'h0020 + 16'($urandom_range(0, 3));
      3:       return 16'h0220 + 16'($urandom_range(0, 3));
      4:       return 16'h01FE + 16'($urandom_range(0, 3));
      5:       return 16'($urandom_range(0, 511));
      6:       return 16'($urandom);
      default: return 16'h0020 + 16'($urandom_range(0, 2));
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 / R4 reset values
    chk("R3 reset pin_oe", pin_oe, 8'h00);
    chk("R4 reset pin_out", pin_out, 8'h00);
    cyc("R3 read dir", 16'h0022, 0, 0, 1, 8'h00);
    cyc("R4 read out", 16'h0021, 0, 0, 1, 8'h00);
    // R11 / R5 direction per bit
    cyc("R11 write dir", 16'h0022, 16'h000F, 1, 1, 8'h00);
    cyc("R11 read dir", 16'h0022, 0, 0, 1, 8'h00);
    chk("R5 oe per bit", pin_oe, 8'h0F);
    // R4 read-modify-write sequence: set, toggle, clear
    cyc("R4 write out", 16'h0021, 16'h0009, 1, 1, 8'h00);
    cyc("R4 readback", 16'h0021, 0, 0, 1, 8'h00);
    cyc("R4 toggle", 16'h0021, 16'h0006, 1, 1, 8'h00);
    chk("R4 toggled", pin_out, 8'h06);
    // R6 synchronizer latency
    cyc("R6 pins pre", 16'h0020, 0, 0, 1, 8'h00);
    cyc("R6 pins edge1", 16'h0020, 0, 0, 1, 8'hA5);
    chk("R6 not yet", bus_rdata, 16'h0000);
    cyc("R6 pins edge2", 16'h0020, 0, 0, 1, 8'hA5);
    cyc("R6 pins seen", 16'h0020, 0, 0, 1, 8'hA5);
    // R7 write to input register ignored
    cyc("R7 write pins", 16'h0020, 16'h00FF, 1, 1, 8'hA5);
    chk("R7 out kept", pin_out, 8'h06);
    chk("R7 dir kept", pin_oe, 8'h0F);
    cyc("R7 pins read", 16'h0020, 0, 0, 1, 8'hA5);
    // R8 unmapped and alias
    cyc("R8 unmapped", 16'h0023, 0, 0, 1, 8'hA5);
    cyc("R8 window top", 16'h01FF, 0, 0, 1, 8'hA5);
    cyc("R8 alias write", 16'h0221, 16'h00EE, 1, 1, 8'hA5);
    chk("R8 alias no effect", pin_out, 8'h06);
    cyc("R8 above window", 16'h0200, 0, 0, 0, 8'hA5);
    // R9 byte lane, R10 word access
    cyc("R9 byte hi ignored", 16'h0021, 16'h5A33, 1, 1, 8'hA5);
    chk("R9 low lane", pin_out, 8'h33);
    cyc("R10 word write", 16'h0021, 16'h3C77, 1, 0, 8'hA5);
    chk("R10 odd byte", pin_out, 8'h3C);
    cyc("R10 word read", 16'h0020, 0, 0, 0, 8'hA5);
    cyc("R10 word dir", 16'h0023, 16'hFF81, 1, 0, 8'hA5);
    chk("R10 even byte", pin_oe, 8'h81);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      cyc("R9 random", pick_addr(), 16'($urandom), 1'($urandom_range(0, 2) == 0),
          1'($urandom_range(0, 3) != 0), 8'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule